// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

This block is an 8-bit general-purpose I/O port with three byte registers on a simple synchronous register bus. One register sets the direction of each pin. One holds the value the pins drive. The third gives write access to that same latch but returns the sampled pad levels when read. Keeping the latch and the pin readback apart lets software do read-modify-write on the driven value without picking up levels forced onto the pads from outside.

The pad side gives each pin an input, an output value and an output enable. Pad inputs pass through a two-flop synchronizer before they can be read. Two side-band inputs mask pins for other uses:
- an analog-select vector, honoured only on the analog-capable bits;
- an oscillator flag, which gives the two top pins to the clock source.

Bit 4 is an open-drain pin. It can pull its pad low but never drives it high.

Top module: `gpio8_port`

## Requirements
- R1: After a synchronous reset the direction register reads 0xFF (all inputs), the latch reads 0x00, every `pad_oe` bit is 0 and `bus_rdata` is 0x00.
- R2: For each push-pull pin, direction bit 1 gives `pad_oe`=0, and direction bit 0 gives `pad_oe`=1 with `pad_out` equal to the latch bit. No pin with direction bit 1 is ever enabled.
- R3: A write with `bus_addr`=0 or `bus_addr`=1 loads the latch, and `bus_addr`=2 loads the direction register. A write with `bus_addr`=3 changes neither register.
- R4: A read with `bus_addr`=1 returns the latch, not the pad levels. A read with `bus_addr`=2 returns the direction register.
- R5: A read with `bus_addr`=0 returns the pad levels through a two-flop synchronizer. A pad change made before clock edge k is returned by a read sampled at edge k+2. Reads sampled at edges k and k+1 still return the old level.
- R6: Read data is registered. `bus_rdata` holds the selected value from the edge that samples `bus_rd`=1 until the next edge. It is 0x00 after an edge that samples `bus_rd`=0, and a read with `bus_addr`=3 returns 0x00.
- R7: An `ana_sel` bit acts only on bits 0..3 and 5. Each such selected bit reads 0 through `bus_addr`=0. Latch reads, direction reads and pad drive are unaffected, and `ana_sel[4]` has no effect.
- R8: While `osc_en`=1, bits 7:6 read 0 in all three registers and `pad_oe[7:6]`=0. The stored bits are kept and show again once `osc_en`=0.
- R9: Pin 4 is open drain. `pad_out[4]` is always 0, and `pad_oe[4]`=1 only when direction bit 4 is 0 and latch bit 4 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 pins/latch, 1 latch, 2 direction |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Levels seen on the pads |
| pad_out | output | 8 | Value driven onto the pads |
| pad_oe | output | 8 | Driver enable per pad |
| ana_sel | input | 8 | Analog selection per pin (capable bits only) |
| osc_en | input | 1 | Oscillator owns bits 7:6 |

## Verification
The latch and the pads are loaded with different patterns (0x3C against 0x5A, then 0xC3). This shows that an address-1 read returns the latch and an address-0 read returns the pins. Writes through address 0 and through address 3 show which writes reach the latch. A pad step from 0x5A to 0xA5, followed by back-to-back reads, shows the exact synchronizer latency. All-ones pads under full analog selection separate the capable bits from bit 4. Latch values with bit 4 set and with bit 4 clear, each with the oscillator flag on and off, separate open-drain drive from push-pull drive and separate read masking from storage loss.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PIN  = 2'd0,
        REG_LAT  = 2'd1,
        REG_DIR  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] lat;
        logic [PORT_W-1:0] dir;
    } port_state_t;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] out;
    } pad_drive_t;

    // Mask of bits lsb..PORT_W-1 when en is set, else zero.
    function automatic logic [PORT_W-1:0] upper_mask(input logic en, input int lsb);
        logic [PORT_W-1:0] m;
        m = '0;
        for (int i = 0; i < PORT_W; i++) begin
            if (en && i >= lsb) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
    import gpio8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output port_state_t       st
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.lat <= '0;
            st.dir <= '1;
        end else if (wr) begin
            case (sel)
                REG_PIN, REG_LAT: st.lat <= wdata;
                REG_DIR:          st.dir <= wdata;
                default:          ;
            endcase
        end
    end

    AST_LAT_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr && (sel == REG_PIN || sel == REG_LAT) |=> st.lat == $past(wdata)); // R3

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr && sel == REG_DIR |=> st.dir == $past(wdata)); // R3

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!wr || sel == REG_NONE) |=> $stable(st)); // R3

endmodule

// File: rtl/gpio8_pad.sv
module gpio8_pad
    import gpio8_pkg::*;
#(
    parameter int OD_PIN  = 4,
    parameter int OSC_LSB = 6
) (
    input  port_state_t st,
    input  logic        osc_en,
    output pad_drive_t  drv
);

    logic [PORT_W-1:0] osc_m;
    logic [PORT_W-1:0] oe_v;
    logic [PORT_W-1:0] out_v;

    assign osc_m = upper_mask(osc_en, OSC_LSB);

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        if (i == OD_PIN) begin : g_od
            // pulls low only; released otherwise
            assign oe_v[i]  = ~st.dir[i] & ~st.lat[i] & ~osc_m[i];
            assign out_v[i] = 1'b0;
        end else begin : g_pp
            assign oe_v[i]  = ~st.dir[i] & ~osc_m[i];
            assign out_v[i] = st.lat[i];
        end
    end

    assign drv = '{oe: oe_v, out: out_v};

endmodule

// File: rtl/gpio8_rdmux.sv
module gpio8_rdmux
    import gpio8_pkg::*;
#(
    parameter logic [PORT_W-1:0] ANA_CAPABLE = 8'h2F,
    parameter int                OSC_LSB     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  port_state_t       st,
    input  logic [PORT_W-1:0] pins,
    input  logic [PORT_W-1:0] ana_sel,
    input  logic              osc_en,
    output logic [PORT_W-1:0] rdata
);

    logic [PORT_W-1:0] osc_m;
    logic [PORT_W-1:0] ana_m;
    logic [PORT_W-1:0] nxt;

    always_comb begin
        osc_m = upper_mask(osc_en, OSC_LSB);
        ana_m = ana_sel & ANA_CAPABLE;
        case (reg_sel_e'(addr))
            REG_PIN: nxt = pins & ~ana_m & ~osc_m;
            REG_LAT: nxt = st.lat & ~osc_m;
            REG_DIR: nxt = st.dir & ~osc_m;
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= nxt;
        else         rdata <= '0;
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd |=> rdata == '0); // R6

    AST_OSC_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd && osc_en |=> rdata[PORT_W-1:OSC_LSB] == '0); // R8

    AST_ANA_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd && reg_sel_e'(addr) == REG_PIN |=> (rdata & $past(ana_sel & ANA_CAPABLE)) == '0); // R7

endmodule

// File: rtl/gpio8_port.sv
module gpio8_port
    import gpio8_pkg::*;
#(
    parameter int                OD_PIN      = 4,
    parameter int                OSC_LSB     = 6,
    parameter int                SYNC_STAGES = 2,
    parameter logic [PORT_W-1:0] ANA_CAPABLE = 8'h2F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    input  logic [PORT_W-1:0] ana_sel,
    input  logic              osc_en
);

    port_state_t       st;
    pad_drive_t        drv;
    logic [PORT_W-1:0] pins_s;

    gpio8_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_s)
    );

    gpio8_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .st    (st)
    );

    gpio8_pad #(.OD_PIN(OD_PIN), .OSC_LSB(OSC_LSB)) u_pad (
        .st     (st),
        .osc_en (osc_en),
        .drv    (drv)
    );

    gpio8_rdmux #(.ANA_CAPABLE(ANA_CAPABLE), .OSC_LSB(OSC_LSB)) u_rdmux (
        .clk     (clk),
        .rst     (rst),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .st      (st),
        .pins    (pins_s),
        .ana_sel (ana_sel),
        .osc_en  (osc_en),
        .rdata   (bus_rdata)
    );

    assign pad_oe  = drv.oe;
    assign pad_out = drv.out;

    AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & st.dir) == '0); // R2

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        pad_oe[OD_PIN] |-> !pad_out[OD_PIN] && !st.lat[OD_PIN]); // R9

    AST_OSC_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        osc_en |-> pad_oe[PORT_W-1:OSC_LSB] == '0); // R8

endmodule

// File: tb/sim_gpio8_port.sv
module sim_gpio8_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] ana_sel = '0;
    logic       osc_en = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen;

    always #10 clk = ~clk;   // 50 MHz

    gpio8_port u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .ana_sel(ana_sel), .osc_en(osc_en)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // driver: issue a read and push its expected value
    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    // monitor: compare registered read data one half cycle after the sampling edge
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(bus_rdata, 8'hxx, "R6 unexpected read data");
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(pad_oe, 8'h00, "R1 pad_oe after reset");
        chk(bus_rdata, 8'h00, "R1 rdata after reset");
        rd(2'd1, 8'h00, "R1 latch after reset");
        rd(2'd2, 8'hFF, "R1 direction after reset");
        rd(2'd0, 8'h00, "R1 pins after reset");

        // R5 pin read path
        pad_in = 8'h5A;
        repeat (3) tick();
        rd(2'd0, 8'h5A, "R5 pins read");

        // R4 latch vs pins
        wr(2'd1, 8'h3C);
        rd(2'd1, 8'h3C, "R4 latch read");
        rd(2'd0, 8'h5A, "R4 pin read not latch");
        chk(pad_oe, 8'h00, "R2 inputs not driven");

        // R2 / R9 drive with bit4 latch high
        wr(2'd2, 8'h00);
        chk(pad_oe, 8'hEF, "R9 od released when latch 1");
        chk(pad_out, 8'h2C, "R2 pad_out follows latch, R9 od bit 0");

        // R3 write through pin address
        wr(2'd0, 8'hC3);
        rd(2'd1, 8'hC3, "R3 write addr0 loads latch");
        chk(pad_out, 8'hC3, "R2 pad_out after addr0 write");
        chk(pad_oe, 8'hFF, "R9 od pulls low");

        // R3 address 3 ignored, R6 address 3 read zero
        wr(2'd3, 8'h77);
        rd(2'd1, 8'hC3, "R3 addr3 write latch unchanged");
        rd(2'd2, 8'h00, "R3 addr3 write direction unchanged");
        rd(2'd3, 8'h00, "R6 addr3 reads zero");
        tick();
        chk(bus_rdata, 8'h00, "R6 rdata zero when idle");

        // R5 synchronizer latency
        pad_in = 8'hA5;
        rd(2'd0, 8'h5A, "R5 edge k old level");
        rd(2'd0, 8'h5A, "R5 edge k+1 old level");
        rd(2'd0, 8'hA5, "R5 edge k+2 new level");

        // R7 analog masking
        ana_sel = 8'hFF;
        pad_in  = 8'hFF;
        repeat (3) tick();
        rd(2'd0, 8'hD0, "R7 analog bits read zero, bit4 digital");
        rd(2'd2, 8'h00, "R7 direction unaffected");
        rd(2'd1, 8'hC3, "R7 latch unaffected");
        chk(pad_oe, 8'hFF, "R7 direction still drives");
        ana_sel = 8'h00;

        // R8 oscillator masking
        osc_en = 1'b1;
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h0F);
        rd(2'd1, 8'h3F, "R8 latch top bits zero");
        rd(2'd2, 8'h0F, "R8 direction top bits zero");
        rd(2'd0, 8'h3F, "R8 pins top bits zero");
        chk(pad_oe, 8'h20, "R8 top pads not driven");
        chk(pad_out, 8'hEF, "R9 od out stays 0");
        osc_en = 1'b0;
        tick();
        rd(2'd1, 8'hFF, "R8 latch bits retained");
        rd(2'd2, 8'h0F, "R8 direction bits retained");
        chk(pad_oe, 8'hE0, "R8 top pads driven again");

        // R9 open-drain with direction input
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h10);
        chk(pad_oe, 8'hEF, "R9 od off when direction input");
        chk(pad_out, 8'h00, "R9 pad_out all zero");
        wr(2'd2, 8'h00);
        chk(pad_oe, 8'hFF, "R9 od on when direction output and latch 0");

        repeat (3) tick();
        chk(8'(exp_q.size()), 8'h00, "R6 all reads returned");
        finish_run();
    end

endmodule